// File: doc/BRIEF.md
# Flash Page Program Sequencer

This block writes a byte stream into a serial NOR flash. A request names a start address and a byte count. The block cuts the request into pieces so that no program command runs past the end of a flash page. For each piece it sets the write-enable latch, waits until the device is idle, and confirms that the latch took effect. It then issues the program frame with the address and passes the caller's bytes through. Finally it polls the busy flag until the device finishes. Status polls are spaced a programmable number of clock cycles apart, and each poll phase is limited to a fixed number of reads.

The block does not shift the serial line itself. It hands complete frame descriptors (opcode, optional address, transmit length, one-byte read) to a separate frame engine and waits for that engine's completion pulse. When the request finishes, the block pulses `req_done` once and presents a result code: success, write-enable failure, or device stuck busy.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, `req_busy`, `req_done` and `fe_start` are low and `req_err` is 0. While the block is idle it starts no frame and forwards no data.
- R2: Each program frame carries `fe_tx_len` equal to the smaller of the remaining count and `PAGE_BYTES - (address mod PAGE_BYTES)`. After each piece the address advances and the remaining count drops by that length, until the count is zero.
- R3: A program frame uses opcode 0x02 with `fe_addr_en` high, `fe_addr` set to the piece's start address and `fe_rd` low. No other frame has `fe_addr_en` high.
- R4: Every piece begins with a write-enable frame (opcode 0x06, no address, no data, no read). Next come status frames (opcode 0x05, `fe_rd` high, length 0) until status bit 0 reads clear. Then one more status frame checks bit 1.
- R5: If the latch-check status frame returns bit 1 clear, the request ends at once with `req_err` = 1 and no program frame.
- R6: After each program frame, status frames repeat until bit 0 reads clear. Only then does the next piece begin or the request complete.
- R7: A poll phase issues at most `MAX_POLLS` status frames. If all of them report bit 0 set, the request ends: with `req_err` = 1 in the write-enable phase, and with `req_err` = 2 after a program frame.
- R8: Each poll status frame starts exactly `POLL_GAP + 1` cycles after the completion pulse that precedes it. Every other frame starts 1 cycle after the preceding completion pulse, and the first write-enable frame starts 1 cycle after `req_start`.
- R9: A request with a count of zero pulses `req_done` 1 cycle after `req_start` with `req_err` = 0 and starts no frame.
- R10: Input bytes go to the frame engine only while a program frame awaits data. Exactly the accepted program lengths are consumed, in stream order.
- R11: `req_busy` is high from the cycle after an accepted `req_start` until completion. `req_done` is a one-cycle pulse, 1 cycle after the last completion pulse, with `req_busy` low. A `req_start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Request strobe, taken while idle |
| req_addr | input | ADDR_W | Flash start address |
| req_len | input | LEN_W | Byte count |
| req_busy | output | 1 | Request in progress |
| req_done | output | 1 | One-cycle completion pulse |
| req_err | output | 2 | Result: 0 ok, 1 write-enable failure, 2 busy timeout |
| in_data | input | 8 | Program data byte |
| in_valid | input | 1 | Program data valid |
| in_ready | output | 1 | Program data accepted |
| fe_start | output | 1 | Frame descriptor strobe |
| fe_opcode | output | 8 | Frame opcode |
| fe_addr_en | output | 1 | Frame carries an address |
| fe_addr | output | ADDR_W | Frame address |
| fe_tx_len | output | LEN_W | Data bytes to transmit |
| fe_rd | output | 1 | Frame reads one status byte |
| fe_tx_data | output | 8 | Data byte to the frame engine |
| fe_tx_valid | output | 1 | Data byte valid |
| fe_tx_ready | input | 1 | Frame engine takes data |
| fe_done | input | 1 | Frame completion pulse |
| fe_rx_byte | input | 8 | Status byte, valid with fe_done |

## Verification
The bench checks every frame strobe against the frame it expects next. It also checks the distance from that strobe to the previous completion pulse or request strobe: one cycle in general, and `POLL_GAP + 1` cycles for a poll read. The completion pulse must appear exactly one cycle after the last frame completion, or one cycle after the strobe for an empty request. `req_busy` must be high one cycle after the strobe. The flash model raises its own completion pulses at known cycles, so each of these distances is exact. All of the bench's sampling happens on the falling clock edge.

// File: rtl/fps_pkg.sv
package fps_pkg;
   localparam logic [7:0] OP_WREN = 8'h06;
   localparam logic [7:0] OP_RDSR = 8'h05;
   localparam logic [7:0] OP_PROG = 8'h02;
   localparam int SR_WIP = 0;
   localparam int SR_WEL = 1;

   typedef enum logic [1:0] {
      ERR_NONE = 2'd0,
      ERR_WEL  = 2'd1,
      ERR_BUSY = 2'd2
   } fps_err_e;

   typedef enum logic [3:0] {
      S_IDLE, S_WREN, S_WREN_W, S_GAP, S_POLL, S_POLL_W,
      S_WEL, S_WEL_W, S_PROG, S_PROG_W
   } fps_state_e;
endpackage

// File: rtl/fps_chunk_calc.sv
module fps_chunk_calc #(
   parameter int ADDR_W     = 24,
   parameter int LEN_W      = 16,
   parameter int PAGE_BYTES = 256
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  remaining,
   output logic [LEN_W-1:0]  chunk
);
   localparam int  OFF_W   = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
   localparam bit  IS_POW2 = (PAGE_BYTES & (PAGE_BYTES - 1)) == 0;

   logic [LEN_W-1:0] offset;
   logic [LEN_W-1:0] room;

   generate
      if (IS_POW2) begin : g_mask
         logic unused_hi;
         assign unused_hi = ^addr;
         assign offset = LEN_W'(addr[OFF_W-1:0]);
      end else begin : g_mod
         assign offset = LEN_W'(addr % ADDR_W'(PAGE_BYTES));
      end
   endgenerate

   assign room  = LEN_W'(PAGE_BYTES) - offset;
   assign chunk = (remaining < room) ? remaining : room;
endmodule

// File: rtl/fps_poll_timer.sv
module fps_poll_timer #(
   parameter int GAP_CYC   = 200000,
   parameter int MAX_POLLS = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gap_run,
   output logic gap_done,
   input  logic retry_clr,
   input  logic retry_inc,
   output logic retry_last
);
   localparam int GW = $clog2(GAP_CYC + 1);
   localparam int RW = $clog2(MAX_POLLS + 1);

   generate
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("GAP_CYC must be at least 1");
      end
      if (MAX_POLLS < 1) begin : g_bad_polls
         $error("MAX_POLLS must be at least 1");
      end
   endgenerate

   logic [GW-1:0] gcnt;
   logic [RW-1:0] rcnt;

   assign gap_done   = gap_run && (gcnt == GW'(GAP_CYC - 1));
   assign retry_last = (rcnt == RW'(MAX_POLLS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gcnt <= '0;
      end else if (!gap_run || gap_done) begin
         gcnt <= '0;
      end else begin
         gcnt <= gcnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rcnt <= '0;
      end else if (retry_clr) begin
         rcnt <= '0;
      end else if (retry_inc) begin
         rcnt <= rcnt + 1'b1;
      end
   end
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
   import fps_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int LEN_W      = 16,
   parameter int PAGE_BYTES = 256,
   parameter int POLL_GAP   = 200000,
   parameter int MAX_POLLS  = 10000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_start,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   output logic              req_busy,
   output logic              req_done,
   output logic [1:0]        req_err,
   input  logic [7:0]        in_data,
   input  logic              in_valid,
   output logic              in_ready,
   output logic              fe_start,
   output logic [7:0]        fe_opcode,
   output logic              fe_addr_en,
   output logic [ADDR_W-1:0] fe_addr,
   output logic [LEN_W-1:0]  fe_tx_len,
   output logic              fe_rd,
   output logic [7:0]        fe_tx_data,
   output logic              fe_tx_valid,
   input  logic              fe_tx_ready,
   input  logic              fe_done,
   input  logic [7:0]        fe_rx_byte
);
   generate
      if (PAGE_BYTES < 2 || PAGE_BYTES >= (1 << LEN_W)) begin : g_bad_page
         $error("PAGE_BYTES must be at least 2 and fit in LEN_W bits");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must be at least 8");
      end
   endgenerate

   fps_state_e        state;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  rem_q;
   logic              post_prog_q;
   logic              done_q;
   fps_err_e          err_q;
   logic [LEN_W-1:0]  chunk;
   logic              gap_done, retry_last, retry_clr, retry_inc;
   logic              wip, wel;
   logic              unused_rx;

   assign wip       = fe_rx_byte[SR_WIP];
   assign wel       = fe_rx_byte[SR_WEL];
   assign unused_rx = ^fe_rx_byte[7:2];

   fps_chunk_calc #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
   ) u_chunk (
      .addr(addr_q), .remaining(rem_q), .chunk(chunk)
   );

   assign retry_clr = fe_done && (state == S_WREN_W || state == S_PROG_W);
   assign retry_inc = fe_done && (state == S_POLL_W) && wip;

   fps_poll_timer #(
      .GAP_CYC(POLL_GAP), .MAX_POLLS(MAX_POLLS)
   ) u_poll (
      .clk(clk), .rst_n(rst_n),
      .gap_run(state == S_GAP), .gap_done(gap_done),
      .retry_clr(retry_clr), .retry_inc(retry_inc), .retry_last(retry_last)
   );

   // Frame descriptor and data path
   always_comb begin
      fe_start   = 1'b0;
      fe_opcode  = 8'h00;
      fe_addr_en = 1'b0;
      fe_tx_len  = '0;
      fe_rd      = 1'b0;
      case (state)
         S_WREN: begin
            fe_start  = 1'b1;
            fe_opcode = OP_WREN;
         end
         S_POLL, S_WEL: begin
            fe_start  = 1'b1;
            fe_opcode = OP_RDSR;
            fe_rd     = 1'b1;
         end
         S_PROG: begin
            fe_start   = 1'b1;
            fe_opcode  = OP_PROG;
            fe_addr_en = 1'b1;
            fe_tx_len  = chunk;
         end
         default: ;
      endcase
   end

   assign fe_addr     = addr_q;
   assign fe_tx_data  = in_data;
   assign fe_tx_valid = in_valid && (state == S_PROG_W);
   assign in_ready    = fe_tx_ready && (state == S_PROG_W);

   assign req_busy = (state != S_IDLE);
   assign req_done = done_q;
   assign req_err  = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         addr_q      <= '0;
         rem_q       <= '0;
         post_prog_q <= 1'b0;
         done_q      <= 1'b0;
         err_q       <= ERR_NONE;
      end else begin
         done_q <= 1'b0;
         case (state)
            S_IDLE: begin
               if (req_start) begin
                  addr_q <= req_addr;
                  rem_q  <= req_len;
                  err_q  <= ERR_NONE;
                  if (req_len == '0) begin
                     done_q <= 1'b1;
                  end else begin
                     state <= S_WREN;
                  end
               end
            end
            S_WREN:   state <= S_WREN_W;
            S_WREN_W: begin
               if (fe_done) begin
                  state       <= S_GAP;
                  post_prog_q <= 1'b0;
               end
            end
            S_GAP: begin
               if (gap_done) state <= S_POLL;
            end
            S_POLL:   state <= S_POLL_W;
            S_POLL_W: begin
               if (fe_done) begin
                  if (wip) begin
                     if (retry_last) begin
                        state  <= S_IDLE;
                        done_q <= 1'b1;
                        err_q  <= post_prog_q ? ERR_BUSY : ERR_WEL;
                     end else begin
                        state <= S_GAP;
                     end
                  end else if (!post_prog_q) begin
                     state <= S_WEL;
                  end else if (rem_q == chunk) begin
                     state  <= S_IDLE;
                     done_q <= 1'b1;
                     err_q  <= ERR_NONE;
                  end else begin
                     addr_q <= addr_q + ADDR_W'(chunk);
                     rem_q  <= rem_q - chunk;
                     state  <= S_WREN;
                  end
               end
            end
            S_WEL:   state <= S_WEL_W;
            S_WEL_W: begin
               if (fe_done) begin
                  if (wel) begin
                     state <= S_PROG;
                  end else begin
                     state  <= S_IDLE;
                     done_q <= 1'b1;
                     err_q  <= ERR_WEL;
                  end
               end
            end
            S_PROG:   state <= S_PROG_W;
            S_PROG_W: begin
               if (fe_done) begin
                  state       <= S_GAP;
                  post_prog_q <= 1'b1;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
   parameter int ADDR_W     = 24,
   parameter int LEN_W      = 16,
   parameter int PAGE_BYTES = 256
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_start,
   input logic              req_busy,
   input logic              req_done,
   input logic              fe_start,
   input logic              fe_addr_en,
   input logic              fe_rd,
   input logic              fe_tx_valid,
   input logic [7:0]        fe_opcode,
   input logic [ADDR_W-1:0] fe_addr,
   input logic [LEN_W-1:0]  fe_tx_len
);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_busy |-> (!fe_start && !fe_tx_valid));

   p_chunk_in_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fe_start && fe_addr_en) |->
         (fe_tx_len != '0 &&
          (int'(fe_addr % ADDR_W'(PAGE_BYTES)) + int'(fe_tx_len)) <= PAGE_BYTES));

   p_prog_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fe_start && fe_opcode == 8'h02) |-> (fe_addr_en && !fe_rd));

   p_frame_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fe_start |=> !fe_start);

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |=> !req_done);

   p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |-> !req_busy);

   p_start_taken_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_start && !req_busy) |=> (req_busy || req_done));
endmodule

bind flash_prog_seq flash_prog_seq_chk #(
   .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_busy(req_busy),
   .req_done(req_done), .fe_start(fe_start), .fe_addr_en(fe_addr_en),
   .fe_rd(fe_rd), .fe_tx_valid(fe_tx_valid), .fe_opcode(fe_opcode),
   .fe_addr(fe_addr), .fe_tx_len(fe_tx_len)
);

// File: tb/flash_prog_seq_test.sv
`timescale 1ns/1ps
module flash_prog_seq_test;
   localparam int AW   = 24;
   localparam int LW   = 16;
   localparam int PG   = 256;
   localparam int GAP  = 3;
   localparam int MAXP = 4;
   localparam int LAT  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_start = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [LW-1:0] req_len = '0;
   logic req_busy, req_done;
   logic [1:0] req_err;
   logic [7:0] in_data = 8'h00;
   logic in_valid = 1'b1;
   logic in_ready;
   logic fe_start, fe_addr_en, fe_rd, fe_tx_valid;
   logic [7:0] fe_opcode, fe_tx_data;
   logic [AW-1:0] fe_addr;
   logic [LW-1:0] fe_tx_len;
   logic fe_tx_ready = 1'b1;
   logic fe_done = 1'b0;
   logic [7:0] fe_rx_byte = 8'h00;

   always #2.5 clk = ~clk;

   flash_prog_seq #(
      .ADDR_W(AW), .LEN_W(LW), .PAGE_BYTES(PG), .POLL_GAP(GAP), .MAX_POLLS(MAXP)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
      .req_len(req_len), .req_busy(req_busy), .req_done(req_done), .req_err(req_err),
      .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
      .fe_start(fe_start), .fe_opcode(fe_opcode), .fe_addr_en(fe_addr_en),
      .fe_addr(fe_addr), .fe_tx_len(fe_tx_len), .fe_rd(fe_rd),
      .fe_tx_data(fe_tx_data), .fe_tx_valid(fe_tx_valid), .fe_tx_ready(fe_tx_ready),
      .fe_done(fe_done), .fe_rx_byte(fe_rx_byte)
   );

   typedef struct {
      logic [7:0] op;
      int         addr;
      int         len;
      bit         rd;
      int         dly;
      bit         from_start;
   } exp_t;

   exp_t exp_q[$];
   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int start_cyc = 0;
   int last_evt = 0;
   int src_idx = 0;
   int cfg_wb = 0, cfg_pb = 0;
   bit cfg_wf = 0;
   bit finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic push(input logic [7:0] op, input int a, input int n, input bit rd,
                       input int dly, input bit fs);
      exp_t e;
      e.op = op; e.addr = a; e.len = n; e.rd = rd; e.dly = dly; e.from_start = fs;
      exp_q.push_back(e);
   endtask

   // Expected frame stream computed from the requirements
   task automatic build(input int a, input int n, input int wb, input int pb, input bit wf,
                        output int err, output int nb);
      int rem, ad, ch, np;
      bit first;
      rem = n; ad = a; first = 1; err = 0; nb = 0;
      while (rem > 0) begin
         ch = PG - (ad % PG);
         if (rem < ch) ch = rem;
         push(8'h06, 0, 0, 0, 1, first);
         first = 0;
         np = (wb >= MAXP) ? MAXP : wb + 1;
         for (int i = 0; i < np; i++) push(8'h05, 0, 0, 1, GAP + 1, 0);
         if (wb >= MAXP) begin err = 1; return; end
         push(8'h05, 0, 0, 1, 1, 0);
         if (wf) begin err = 1; return; end
         push(8'h02, ad, ch, 0, 1, 0);
         nb += ch;
         np = (pb >= MAXP) ? MAXP : pb + 1;
         for (int i = 0; i < np; i++) push(8'h05, 0, 0, 1, GAP + 1, 0);
         if (pb >= MAXP) begin err = 2; return; end
         ad += ch;
         rem -= ch;
      end
   endtask

   // Flash and frame engine model, compared against the expected stream every clock
   initial begin : model
      int lat_cnt, pp_left, busy_left, refc;
      bit wel_q;
      logic [7:0] rx_pend;
      exp_t e;
      lat_cnt = 0; pp_left = 0; busy_left = 0; wel_q = 0; rx_pend = 8'h00;
      forever begin
         @(negedge clk);
         fe_done = 1'b0;
         if (rst_n) begin
            if (fe_tx_valid) begin
               if (pp_left > 0) begin
                  chk(fe_tx_data == src_idx[7:0], "R10 data order", fe_tx_data, src_idx[7:0]);
                  src_idx++;
                  in_data = src_idx[7:0];
                  pp_left--;
                  if (pp_left == 0) begin
                     fe_done = 1'b1;
                     last_evt = cyc;
                     busy_left = cfg_pb;
                     wel_q = 0;
                  end
               end else begin
                  chk(0, "R10 data outside program", 1, 0);
               end
            end
            if (lat_cnt > 0) begin
               lat_cnt--;
               if (lat_cnt == 0) begin
                  fe_done = 1'b1;
                  fe_rx_byte = rx_pend;
                  last_evt = cyc;
               end
            end
            if (fe_start) begin
               if (exp_q.size() == 0) begin
                  chk(0, "R4 unexpected frame", fe_opcode, 0);
               end else begin
                  e = exp_q.pop_front();
                  refc = e.from_start ? start_cyc : last_evt;
                  chk(fe_opcode == e.op, "R4 opcode", fe_opcode, e.op);
                  chk(fe_rd == e.rd, "R4 read flag", fe_rd, e.rd);
                  chk(fe_tx_len == e.len, "R2 chunk length", fe_tx_len, e.len);
                  chk(fe_addr_en == (e.op == 8'h02), "R3 address enable", fe_addr_en, e.op == 8'h02);
                  if (e.op == 8'h02) chk(fe_addr == e.addr, "R3 chunk address", fe_addr, e.addr);
                  chk(cyc - refc == e.dly, "R8 frame spacing", cyc - refc, e.dly);
               end
               case (fe_opcode)
                  8'h06: begin
                     wel_q = !cfg_wf;
                     busy_left = cfg_wb;
                     lat_cnt = LAT;
                  end
                  8'h05: begin
                     rx_pend = {6'b0, wel_q, busy_left > 0};
                     if (busy_left > 0) busy_left--;
                     lat_cnt = LAT;
                  end
                  default: pp_left = fe_tx_len;
               endcase
            end
         end
      end
   end

   task automatic run_req(input int a, input int n, input int wb, input int pb, input bit wf,
                          input bit poke, input string tag);
      int exp_err, nb, base, w;
      cfg_wb = wb; cfg_pb = pb; cfg_wf = wf;
      build(a, n, wb, pb, wf, exp_err, nb);
      base = src_idx;
      @(negedge clk);
      req_addr = AW'(a); req_len = LW'(n); req_start = 1'b1; start_cyc = cyc;
      @(negedge clk);
      req_start = 1'b0;
      if (n != 0) chk(req_busy == 1'b1, "R11 busy after start", req_busy, 1);
      w = 0;
      while (!req_done && w < 20000) begin
         if (poke && w == 8) begin
            req_start = 1'b1; req_addr = 24'h000555; req_len = 16'd7;
         end
         @(negedge clk);
         req_start = 1'b0;
         w++;
      end
      chk(req_done == 1'b1, "R11 done seen", req_done, 1);
      chk(req_busy == 1'b0, "R11 idle at done", req_busy, 0);
      chk(req_err == 2'(exp_err), tag, req_err, exp_err);
      if (n == 0) chk(cyc - start_cyc == 1, "R9 empty request latency", cyc - start_cyc, 1);
      else chk(cyc - last_evt == 1, "R11 done latency", cyc - last_evt, 1);
      chk(exp_q.size() == 0, "R6 all polls issued", exp_q.size(), 0);
      chk(src_idx - base == nb, "R10 byte count", src_idx - base, nb);
      @(negedge clk);
      chk(req_done == 1'b0, "R11 done one cycle", req_done, 0);
      exp_q.delete();
   endtask

   initial begin : watchdog
      #1000000;
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      chk(req_busy == 1'b0, "R1 busy in reset", req_busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_busy == 1'b0, "R1 busy after reset", req_busy, 0);
      chk(req_done == 1'b0, "R1 done after reset", req_done, 0);
      chk(fe_start == 1'b0, "R1 no frame after reset", fe_start, 0);
      chk(req_err == 2'd0, "R1 result after reset", req_err, 0);

      run_req(24'h000000, 0,   0, 0, 0, 0, "R9 empty request result");
      run_req(24'h000010, 5,   0, 0, 0, 0, "R4 single chunk result");
      run_req(24'h0001F0, 40,  1, 2, 0, 1, "R2 page crossing result");
      run_req(24'h000300, 300, 0, 1, 0, 0, "R2 full page result");
      run_req(24'h0000FC, 4,   2, 0, 0, 0, "R2 ends on boundary result");
      run_req(24'h000020, 10,  0, 0, 1, 0, "R5 latch clear result");
      run_req(24'h000040, 8,   MAXP, 0, 0, 0, "R7 enable poll timeout result");
      run_req(24'h0000FE, 3,   0, MAXP - 1, 0, 0, "R7 last poll succeeds result");
      run_req(24'h0000F0, 32,  0, MAXP, 0, 0, "R7 program poll timeout result");

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule